// File: doc/BRIEF.md
# Pulse Event Accumulator

This block counts activity on a single external pin into an 8-bit register that software can read and preload. It has two modes. In edge mode, each chosen transition of the pin adds one to the count. In gated mode, the count advances once per 64 system clocks for as long as the pin holds its chosen active level. This turns the register into a timer that measures how long the pin stays active.

A single polarity bit serves both modes. In edge mode it picks the falling or the rising edge. In gated mode it picks active-high or active-low. Two sticky flags report events to software:

- an overflow flag, set when the count wraps from its top value to zero;
- an edge flag, set on the selected edge. In gated mode this is the edge that ends the active level.

Each flag has its own interrupt enable. A single interrupt line combines the two enabled flags. Software drives all of this through a small write port.

Top module: `pulse_tally`

## Requirements
- R1: After reset, the count is 0, both flags are 0, the interrupt output is 0 and every control bit is 0. The divide-by-64 prescaler also restarts from 0.
- R2: While the enable bit is 0, the count does not change except through a software write, and the edge flag never sets, whatever the pin does.
- R3: Edge mode with polarity 0 (falling edge). Each falling edge of the pin adds exactly one to the count. The new value is visible after the third rising clock edge that follows the pin change, because of two synchronizer flops plus the count register.
- R4: Edge mode with polarity 1 (rising edge). Each rising edge of the pin adds exactly one to the count, with the same latency as in R3.
- R5: Gated mode with polarity 0 (active high). The count adds one on each prescaler tick during which the synchronized pin is high. A tick is every 64th clock, and the first increment can occur on the 64th rising edge after reset is released.
- R6: Gated mode with polarity 1 (active low). The count adds one on each prescaler tick during which the synchronized pin is low.
- R7: The prescaler never stops and is never reset by a change of the pin, the mode or the enable bit. A gated period that begins part-way through an interval gets its first increment at the next regular tick.
- R8: When an increment takes the count from 255 to 0, the overflow flag sets. Writing a 1 to bit 0 at address 2 clears it. If a set and a clear happen in the same cycle, the set wins.
- R9: The edge flag sets on the selected edge while the enable bit is 1:
  - in edge mode, on the counted edge;
  - in gated mode, on the edge that ends the active level (falling for polarity 0, rising for polarity 1).

  Writing a 1 to bit 1 at address 2 clears it. If a set and a clear happen in the same cycle, the set wins.
- R10: The interrupt output is 1 exactly when (overflow flag AND control bit 3) OR (edge flag AND control bit 4) is true.
- R11: A write to address 1 loads the count from the write data on the next clock. This load takes priority over an increment in the same cycle, and that increment is then lost without setting overflow.
- R12: A write to address 0 sets the control bits from the data on the next clock, as follows:

  | Data bit | Meaning |
  |---|---|
  | 0 | enable |
  | 1 | mode (0 = edge, 1 = gated) |
  | 2 | polarity |
  | 3 | overflow interrupt enable |
  | 4 | edge interrupt enable |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 count, 2 flag clear |
| wrData | input | 8 | Write data |
| pinIn | input | 1 | Asynchronous external input |
| count | output | 8 | Current count value |
| ovfFlag | output | 1 | Sticky overflow flag |
| edgeFlag | output | 1 | Sticky input-edge flag |
| irq | output | 1 | Combined enabled interrupt request |

## Verification
The pin is first toggled slowly while the block is disabled, which shows that nothing moves. It is then toggled in edge mode with each polarity; counting twice per pulse, or counting the wrong edge, would show up as a difference in both the count and the edge flag.

Long high and low stretches in gated mode, started at arbitrary points in the prescaler interval, separate correct tick-rate counting from per-clock counting, from inverted gating and from a prescaler that restarts. A preload near 255, followed by further events and by clears written while events are still arriving, exercises wrap detection and the priority of set over clear.

// File: rtl/pulse_tally_pkg.sv
package pulse_tally_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR = 2'd2;

  // Bit order matches the control write encoding: bit 0 enable ... bit 4 edgeIe
  typedef struct packed {
    logic edgeIe;
    logic ovfIe;
    logic polarity;
    logic mode;
    logic enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Per-cycle requests from the control side to the datapath
  typedef struct packed {
    logic step;
    logic edgeHit;
  } strobe_t;
endpackage

// File: rtl/pulse_tally_ctrl.sv
module pulse_tally_ctrl
  import pulse_tally_pkg::*;
#(
  parameter int PRESCALE    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pinIn,
  input  ctrl_t   ctrlQ,
  output strobe_t strb
);
  localparam int DIV_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRESCALE - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   pinLvl;
  logic                   pinPrev;
  logic [DIV_W-1:0]       divCnt;
  logic                   tick;
  logic                   riseSeen;
  logic                   fallSeen;
  logic                   selEdge;
  logic                   gateActive;

  // Two-or-more flop synchronizer chain
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncChain[i] <= 1'b0;
      end else begin
        if (i == 0) syncChain[i] <= pinIn;
        else        syncChain[i] <= syncChain[(i == 0) ? 0 : i - 1];
      end
    end
  end

  assign pinLvl = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= pinLvl;
  end

  // Free-running time base, independent of every control bit
  always_ff @(posedge clk) begin
    if (!rstN)                divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                      divCnt <= divCnt + 1'b1;
  end

  assign tick       = (divCnt == DIV_LAST);
  assign riseSeen   = pinLvl & ~pinPrev;
  assign fallSeen   = ~pinLvl & pinPrev;
  // Polarity 0: falling edge / active high; polarity 1: rising edge / active low.
  // In gated mode the selected edge is therefore the one ending the active level.
  assign selEdge    = ctrlQ.polarity ? riseSeen : fallSeen;
  assign gateActive = pinLvl ^ ctrlQ.polarity;

  always_comb begin
    strb.edgeHit = ctrlQ.enable & selEdge;
    if (ctrlQ.mode) strb.step = ctrlQ.enable & tick & gateActive;
    else            strb.step = ctrlQ.enable & selEdge;
  end
endmodule

// File: rtl/pulse_tally_dp.sv
module pulse_tally_dp
  import pulse_tally_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  strobe_t           strb,
  output ctrl_t             ctrlQ,
  output logic [CNT_W-1:0]  count,
  output logic              ovfFlag,
  output logic              edgeFlag,
  output logic              irq
);
  logic ctrlWr;
  logic cntWr;
  logic clrWr;
  logic wrapHit;

  assign ctrlWr  = wrEn && (wrAddr == ADDR_CTRL);
  assign cntWr   = wrEn && (wrAddr == ADDR_COUNT);
  assign clrWr   = wrEn && (wrAddr == ADDR_CLEAR);
  assign wrapHit = strb.step && (count == '1) && !cntWr;

  always_ff @(posedge clk) begin
    if (!rstN)       ctrlQ <= '0;
    else if (ctrlWr) ctrlQ <= ctrl_t'(wrData[CTRL_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          count <= '0;
    else if (cntWr)     count <= wrData;
    else if (strb.step) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   ovfFlag <= 1'b0;
    else if (wrapHit)            ovfFlag <= 1'b1;
    else if (clrWr && wrData[0]) ovfFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   edgeFlag <= 1'b0;
    else if (strb.edgeHit)       edgeFlag <= 1'b1;
    else if (clrWr && wrData[1]) edgeFlag <= 1'b0;
  end

  assign irq = (ovfFlag & ctrlQ.ovfIe) | (edgeFlag & ctrlQ.edgeIe);
endmodule

// File: rtl/pulse_tally.sv
module pulse_tally
  import pulse_tally_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRESCALE    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              pinIn,
  output logic [CNT_W-1:0]  count,
  output logic              ovfFlag,
  output logic              edgeFlag,
  output logic              irq
);
  ctrl_t   ctrlQ;
  strobe_t strb;

  pulse_tally_ctrl #(
    .PRESCALE   (PRESCALE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .pinIn(pinIn),
    .ctrlQ(ctrlQ),
    .strb (strb)
  );

  pulse_tally_dp #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strb    (strb),
    .ctrlQ   (ctrlQ),
    .count   (count),
    .ovfFlag (ovfFlag),
    .edgeFlag(edgeFlag),
    .irq     (irq)
  );
endmodule

// File: rtl/pulse_tally_chk.sv
module pulse_tally_chk
  import pulse_tally_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [CNT_W-1:0]  wrData,
  input logic [CNT_W-1:0]  count,
  input logic              ovfFlag,
  input logic              edgeFlag,
  input logic              irq,
  input logic              accEn
);
  logic cntWr;
  logic edgeClr;

  assign cntWr   = wrEn && (wrAddr == ADDR_COUNT);
  assign edgeClr = wrEn && (wrAddr == ADDR_CLEAR) && wrData[1];

  // R2: a disabled accumulator only changes through a software load
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!accEn && !cntWr) |=> $stable(count));

  // R3: without a load, the count moves by exactly one
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cntWr) && (count != $past(count))) |-> (count == $past(count) + CNT_W'(1)));

  // R8: a wrap from all-ones to zero leaves the overflow flag set
  a_r8_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cntWr) && ($past(count) == '1) && (count == '0)) |-> ovfFlag);

  // R9: the edge flag stays set until a clear is written
  a_r9_edge_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (edgeFlag && !edgeClr) |=> edgeFlag);

  // R10: an interrupt always has a flag behind it
  a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ovfFlag || edgeFlag));
endmodule

bind pulse_tally pulse_tally_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .count   (count),
  .ovfFlag (ovfFlag),
  .edgeFlag(edgeFlag),
  .irq     (irq),
  .accEn   (ctrlQ.enable)
);

// File: tb/pulse_tally_test.sv
`timescale 1ns/1ps
module pulse_tally_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       pinIn = 1'b0;
  logic [7:0] count;
  logic       ovfFlag;
  logic       edgeFlag;
  logic       irq;

  int    nCmp = 0;
  int    nBad = 0;
  string curReq = "R1";
  bit    started = 1'b0;

  always #2.5 clk = ~clk;

  pulse_tally uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinIn(pinIn), .count(count), .ovfFlag(ovfFlag), .edgeFlag(edgeFlag), .irq(irq)
  );

  // Behavioural reference model
  bit       mS1, mS2, mPrev;
  int       mDiv;
  bit [7:0] mCnt;
  bit       mOvf, mEdge;
  bit [4:0] mCtrl;
  bit       vSel, vTick, vStep, vCntW, vClrW, vOvfSet;
  int       pinQ[$];

  always @(posedge clk) begin
    started = 1'b1;
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mPrev = 0; mDiv = 0; mCnt = 0;
      mOvf = 0; mEdge = 0; mCtrl = 0;
      pinQ = {};
    end else begin
      vSel  = mCtrl[2] ? (mS2 && !mPrev) : (!mS2 && mPrev);
      vTick = (mDiv == 63);
      vStep = mCtrl[0] && (mCtrl[1] ? (vTick && (mS2 ^ mCtrl[2])) : vSel);
      vCntW = wrEn && (wrAddr == 2'd1);
      vClrW = wrEn && (wrAddr == 2'd2);
      vOvfSet = vStep && (mCnt == 8'hFF) && !vCntW;
      if (vCntW) mCnt = wrData;
      else if (vStep) mCnt = mCnt + 8'd1;
      if (vOvfSet) mOvf = 1;
      else if (vClrW && wrData[0]) mOvf = 0;
      if (mCtrl[0] && vSel) mEdge = 1;
      else if (vClrW && wrData[1]) mEdge = 0;
      if (wrEn && wrAddr == 2'd0) mCtrl = wrData[4:0];
      pinQ.push_back(int'(pinIn));
      mPrev = mS2;
      mS2 = mS1;
      mS1 = pinIn;
      mDiv = (mDiv + 1) % 64;
    end
  end

  task automatic cmp(string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      cmp("count", int'(count), int'(mCnt));
      cmp("ovfFlag", int'(ovfFlag), int'(mOvf));
      cmp("edgeFlag", int'(edgeFlag), int'(mEdge));
      cmp("irq", int'(irq), int'((mOvf && mCtrl[3]) || (mEdge && mCtrl[4])));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulses(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pinIn = 1'b1;
      idle(gap);
      @(negedge clk); pinIn = 1'b0;
      idle(gap);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    rstN = 1'b1;
    idle(3);

    curReq = "R2";
    pulses(4, 5);
    idle(70);

    curReq = "R12";
    wr(2'd0, 8'h01);
    curReq = "R3";
    pulses(5, 4);
    idle(5);

    curReq = "R4";
    wr(2'd0, 8'h05);
    pulses(3, 3);
    idle(5);

    curReq = "R9";
    wr(2'd2, 8'h02);
    idle(4);

    curReq = "R11";
    wr(2'd1, 8'hFE);
    curReq = "R8";
    pulses(3, 4);
    idle(5);
    wr(2'd2, 8'h01);

    curReq = "R10";
    wr(2'd0, 8'h19);
    pulses(2, 4);
    idle(4);
    wr(2'd2, 8'h03);
    idle(3);
    wr(2'd0, 8'h0D);
    wr(2'd1, 8'hFF);
    pulses(1, 3);
    idle(4);

    curReq = "R5";
    wr(2'd0, 8'h1B);
    wr(2'd1, 8'h00);
    idle(17);
    @(negedge clk); pinIn = 1'b1;
    idle(300);
    @(negedge clk); pinIn = 1'b0;
    idle(100);

    curReq = "R6";
    wr(2'd0, 8'h1F);
    idle(230);
    @(negedge clk); pinIn = 1'b1;
    idle(90);

    curReq = "R7";
    wr(2'd0, 8'h0B);
    idle(41);
    @(negedge clk); pinIn = 1'b0;
    @(negedge clk); pinIn = 1'b1;
    idle(200);

    curReq = "R8";
    wr(2'd1, 8'hFC);
    for (int k = 0; k < 40; k++) begin
      wr(2'd2, 8'h03);
      idle(9);
    end
    curReq = "R11";
    for (int k = 0; k < 20; k++) begin
      wr(2'd1, 8'(k * 13));
      idle(7 + k);
    end
    @(negedge clk); pinIn = 1'b0;
    idle(10);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired during %s actual=running expected=done", curReq);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule